// File: doc/BRIEF.md
# Two-Wire Switch Management Bus Master

This block is the master side of a two-wire serial management link to an attached switch device. It carries 16-bit register reads and writes at 16-bit addresses. The host posts one request at a time: an address, write data and a read/write select, qualified by a single-cycle `start`. The block raises `busy` for the whole transfer. When the transfer ends it pulses `done` for one cycle, and the error flag and the read data are valid in that same cycle.

On the pin side the block drives a clock line and a data line. Each line has its own output enable, so the pad logic can release either one. Every line change is held for one programmable step of `half_div + 1` clock cycles. A transfer has the following parts:

- An opening pattern with two clock pulses.
- A command byte that carries the direction.
- The address, low byte first.
- The data, either sent as two bytes or received as two bytes.
- A closing pattern with extra clock pulses, after which both lines are released.

After every byte the master sends, it polls the device for an acknowledge a bounded number of times. If no acknowledge arrives within that bound, the transfer is cut short and the closing pattern is sent at once.

Top module: `mgmt_bus_master`

## Requirements
- R1: The opening pattern starts from clock low and data high. It gives one full clock pulse, raises the clock again, pulls data low while the clock is high, lowers the clock, and then raises data. This gives two clock rises, and data falls while the clock is high exactly once.
- R2: The first byte is the command: 0xA9 for a read and 0xA8 for a write. Bits 7:4 are 0xA, bits 3:1 are 3'b100, and bit 0 is 1 for a read.
- R3: Bytes are sent MSB first. Data changes only while the clock is low and is valid at each clock rise. The address follows the command, low byte and then high byte.
- R4: A write sends the data low byte and then the data high byte. Each byte is followed by an acknowledge slot.
- R5: In a read, the master releases data and samples it while the clock is high, once per clock pulse. It assembles the bits MSB first, low byte first. At `done`, `rdata` = {high byte, low byte}.
- R6: After the received low byte the master drives a 0 for one clock pulse. After the received high byte it drives a 1.
- R7: In an acknowledge slot the master releases data, pulses the clock and samples. A sampled 0 is an acknowledge. A sampled 1 repeats the slot, and an acknowledge after up to RETRY_MAX (default 5) refusals lets the transfer go on.
- R8: If RETRY_MAX + 1 slots in a row are refused, the block sends no more bytes and goes straight to the closing pattern. It then reports `err` = 1 with `done`.
- R9: The closing pattern takes 8 steps with 3 clock rises. It raises the clock, raises data while the clock is high, and gives two more clock pulses. It then drops both output enables. Both enables are low whenever the block is idle.
- R10: Each line step lasts `half_div + 1` cycles. A transfer with no refusals takes 150 steps. Each refused slot adds 3 steps.
- R11: A `start` is taken only while idle. `busy` rises in the cycle after the request is accepted and stays high until `done`. A `start` while busy has no effect.
- R12: `done` is high for exactly one cycle. `err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when idle |
| rd | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Register address |
| wdata | input | 16 | Write data |
| half_div | input | DIV_W | Step length minus one, in clock cycles |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Acknowledge timeout, valid with done |
| rdata | output | 16 | Read data, valid with done |
| sck_o | output | 1 | Clock line value |
| sck_oe | output | 1 | Clock line enable |
| sda_o | output | 1 | Data line value |
| sda_oe | output | 1 | Data line enable |
| sda_i | input | 1 | Data line as seen at the pad |

## Verification
The bench builds the block with the default DIV_W = 8 and RETRY_MAX = 5, which puts the full retry bound within reach. It can then show both the fifth refusal being followed by a good acknowledge and the sixth refusal aborting the transfer. The bench drives `half_div` at runtime with 2 and with 0. This checks the exact cycle count of a transfer for a multi-cycle step and for the single-cycle minimum, where the divider ticks every cycle.

// File: rtl/mgb_pkg.sv
package mgb_pkg;

    localparam logic [3:0] CMD_TAG = 4'hA;
    localparam logic [2:0] CMD_SUB = 3'b100;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_TX,
        PH_ACK,
        PH_RX,
        PH_MACK,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic        rd;
        logic [15:0] addr;
        logic [15:0] wdata;
    } req_t;

    typedef struct packed {
        logic sck;
        logic sck_oe;
        logic sda;
        logic sda_oe;
    } pins_t;

    function automatic logic [7:0] frame_byte(input req_t r, input logic [2:0] idx);
        case (idx)
            3'd0:    return {CMD_TAG, CMD_SUB, r.rd};
            3'd1:    return r.addr[7:0];
            3'd2:    return r.addr[15:8];
            3'd3:    return r.wdata[7:0];
            default: return r.wdata[15:8];
        endcase
    endfunction

endpackage

// File: rtl/mgb_tick.sv
module mgb_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mgb_seq.sv
module mgb_seq
    import mgb_pkg::*;
#(
    parameter int RETRY_MAX = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        start,
    input  req_t        req_in,
    input  logic        sda_i,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output pins_t       pins
);
    localparam int RTW = $clog2(RETRY_MAX + 1);
    localparam logic [2:0] IDX_ADDR_HI = 3'd2;
    localparam logic [2:0] IDX_RX_LO   = 3'd3;
    localparam logic [2:0] IDX_LAST    = 3'd4;

    phase_e         phase;
    logic [2:0]     step;
    logic [2:0]     bitn;
    logic [2:0]     idx;
    logic [RTW-1:0] retry;
    req_t           req;
    logic [6:0]     shreg;
    logic           err_flag;
    logic [7:0]     cur_byte;

    assign busy     = (phase != PH_IDLE);
    assign cur_byte = frame_byte(req, idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            step     <= '0;
            bitn     <= '0;
            idx      <= '0;
            retry    <= '0;
            req      <= '0;
            shreg    <= '0;
            err_flag <= 1'b0;
            rdata    <= '0;
            pins     <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    req      <= req_in;
                    phase    <= PH_START;
                    step     <= '0;
                    err_flag <= 1'b0;
                    rdata    <= '0;
                end
            end else if (tick) begin
                case (phase)
                    PH_START: begin
                        case (step)
                            3'd0:       pins <= '{sck: 1'b0, sck_oe: 1'b1, sda: 1'b1, sda_oe: 1'b1};
                            3'd1, 3'd3: pins.sck <= 1'b1;
                            3'd2, 3'd5: pins.sck <= 1'b0;
                            3'd4:       pins.sda <= 1'b0;
                            default:    pins.sda <= 1'b1;
                        endcase
                        if (step == 3'd6) begin
                            phase <= PH_TX;
                            step  <= '0;
                            bitn  <= 3'd7;
                            idx   <= '0;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                    PH_TX: begin
                        case (step)
                            3'd0: begin
                                pins.sda    <= cur_byte[bitn];
                                pins.sda_oe <= 1'b1;
                            end
                            3'd1:    pins.sck <= 1'b1;
                            default: pins.sck <= 1'b0;
                        endcase
                        if (step == 3'd2) begin
                            step <= '0;
                            if (bitn == 3'd0) begin
                                phase <= PH_ACK;
                                retry <= '0;
                            end else begin
                                bitn <= bitn - 1'b1;
                            end
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                    PH_ACK, PH_RX: begin
                        case (step)
                            3'd0:    pins.sda_oe <= 1'b0;
                            3'd1:    pins.sck <= 1'b1;
                            default: pins.sck <= 1'b0;
                        endcase
                        if (step != 3'd2) begin
                            step <= step + 1'b1;
                        end else begin
                            step <= '0;
                            if (phase == PH_RX) begin
                                shreg <= {shreg[5:0], sda_i};
                                if (bitn == 3'd0) begin
                                    if (idx == IDX_RX_LO) rdata[7:0]  <= {shreg, sda_i};
                                    else                  rdata[15:8] <= {shreg, sda_i};
                                    phase <= PH_MACK;
                                end else begin
                                    bitn <= bitn - 1'b1;
                                end
                            end else if (!sda_i) begin
                                pins.sda_oe <= 1'b1;
                                pins.sda    <= 1'b0;
                                bitn        <= 3'd7;
                                idx         <= idx + 1'b1;
                                if (!req.rd && idx == IDX_LAST)      phase <= PH_STOP;
                                else if (req.rd && idx == IDX_ADDR_HI) phase <= PH_RX;
                                else                                   phase <= PH_TX;
                            end else if (retry == RTW'(RETRY_MAX)) begin
                                err_flag <= 1'b1;
                                phase    <= PH_STOP;
                            end else begin
                                retry <= retry + 1'b1;
                            end
                        end
                    end
                    PH_MACK: begin
                        case (step)
                            3'd0: begin
                                pins.sda_oe <= 1'b1;
                                pins.sda    <= (idx != IDX_RX_LO);
                            end
                            3'd1:    pins.sck <= 1'b1;
                            default: pins.sck <= 1'b0;
                        endcase
                        if (step == 3'd2) begin
                            step <= '0;
                            if (idx == IDX_RX_LO) begin
                                idx   <= IDX_LAST;
                                bitn  <= 3'd7;
                                phase <= PH_RX;
                            end else begin
                                phase <= PH_STOP;
                            end
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        case (step)
                            3'd0: begin
                                pins.sda_oe <= 1'b1;
                                pins.sda    <= 1'b0;
                                pins.sck    <= 1'b1;
                            end
                            3'd1:             pins.sda <= 1'b1;
                            3'd2, 3'd4, 3'd6: pins.sck <= 1'b1;
                            3'd3, 3'd5:       pins.sck <= 1'b0;
                            default: begin
                                pins  <= '0;
                                done  <= 1'b1;
                                err   <= err_flag;
                                phase <= PH_IDLE;
                            end
                        endcase
                        if (step != 3'd7) step <= step + 1'b1;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
    import mgb_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int RETRY_MAX = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rd,
    input  logic [15:0]      addr,
    input  logic [15:0]      wdata,
    input  logic [DIV_W-1:0] half_div,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [15:0]      rdata,
    output logic             sck_o,
    output logic             sck_oe,
    output logic             sda_o,
    output logic             sda_oe,
    input  logic             sda_i
);
    logic  tick;
    req_t  req;
    pins_t pins;

    assign req = '{rd: rd, addr: addr, wdata: wdata};

    mgb_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .run   (busy),
        .limit (half_div),
        .tick  (tick)
    );

    mgb_seq #(.RETRY_MAX(RETRY_MAX)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .start  (start),
        .req_in (req),
        .sda_i  (sda_i),
        .busy   (busy),
        .done   (done),
        .err    (err),
        .rdata  (rdata),
        .pins   (pins)
    );

    assign sck_o  = pins.sck;
    assign sck_oe = pins.sck_oe;
    assign sda_o  = pins.sda;
    assign sda_oe = pins.sda_oe;
endmodule

// File: rtl/mgmt_bus_master_chk.sv
module mgmt_bus_master_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic err,
    input logic sck_oe,
    input logic sda_oe
);
    assert_release_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sck_oe && !sda_oe));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_with_done_R12: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    assert_busy_until_done_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_accept_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind mgmt_bus_master mgmt_bus_master_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .sck_oe (sck_oe),
    .sda_oe (sda_oe)
);

// File: tb/test_mgmt_bus_master.sv
module test_mgmt_bus_master;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             rd = 1'b0;
    logic [15:0]      addr = '0;
    logic [15:0]      wdata = '0;
    logic [DIV_W-1:0] half_div = 8'd2;
    logic             busy, done, err;
    logic [15:0]      rdata;
    logic             sck_o, sck_oe, sda_o, sda_oe;
    logic             sda_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mgmt_bus_master i_mgmt_bus_master (
        .clk(clk), .rst(rst), .start(start), .rd(rd), .addr(addr), .wdata(wdata),
        .half_div(half_div), .busy(busy), .done(done), .err(err), .rdata(rdata),
        .sck_o(sck_o), .sck_oe(sck_oe), .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    // line monitor, sampled away from the active edge
    int   rises = 0;
    int   hi_changes = 0;
    logic p_sck = 1'b0, p_sda = 1'b0, p_oe = 1'b0;
    always @(negedge clk) begin
        if (sck_o && !p_sck) rises++;
        if (sck_o && p_sck && sda_oe && p_oe && (sda_o != p_sda)) hi_changes++;
        p_sck = sck_o;
        p_sda = sda_o;
        p_oe  = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // captured bus traffic
    logic [7:0] cap [5];
    logic       mack_v [2];
    logic       mack_oe [2];
    bit         aborted;

    task automatic slave(input bit is_rd, input int nack_byte, input int nack_num,
                         input logic [15:0] rdv);
        int ntx;
        ntx = is_rd ? 3 : 5;
        aborted = 1'b0;
        for (int b = 0; b < 5; b++) cap[b] = 8'h00;
        repeat (2) @(posedge sck_o);
        for (int b = 0; b < ntx; b++) begin
            logic [7:0] v;
            int attempts;
            v = 8'h00;
            for (int i = 0; i < 8; i++) begin
                @(posedge sck_o);
                v = {v[6:0], sda_o};
            end
            cap[b] = v;
            attempts = 0;
            forever begin
                sda_i = (b == nack_byte && attempts < nack_num);
                @(posedge sck_o);
                @(negedge sck_o);
                if (!sda_i) break;
                attempts++;
                if (attempts == 6) begin
                    sda_i = 1'b1;
                    aborted = 1'b1;
                    return;
                end
            end
            sda_i = 1'b1;
        end
        if (is_rd) begin
            for (int h = 0; h < 2; h++) begin
                for (int i = 0; i < 8; i++) begin
                    sda_i = rdv[h*8 + 7 - i];
                    @(posedge sck_o);
                    @(negedge sck_o);
                end
                sda_i = 1'b1;
                @(posedge sck_o);
                mack_v[h]  = sda_o;
                mack_oe[h] = sda_oe;
            end
        end
    endtask

    int         cyc;
    logic       err_v;
    logic [15:0] rdata_v;
    logic       done_after;

    task automatic host(input bit is_rd, input logic [15:0] a, input logic [15:0] d,
                        input logic [7:0] hd, input bit poke);
        @(negedge clk);
        half_div = hd;
        rd = is_rd;
        addr = a;
        wdata = d;
        start = 1'b1;
        rises = 0;
        hi_changes = 0;
        @(posedge clk);
        cyc = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (poke && cyc == 40) begin
                rd = ~is_rd;
                addr = ~a;
                wdata = ~d;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        err_v = err;
        rdata_v = rdata;
        @(negedge clk);
        done_after = done;
    endtask

    task automatic txn(input bit is_rd, input logic [15:0] a, input logic [15:0] d,
                       input logic [7:0] hd, input int nb, input int nn,
                       input logic [15:0] rdv, input bit poke);
        fork
            host(is_rd, a, d, hd, poke);
            slave(is_rd, nb, nn, rdv);
        join
    endtask

    task automatic check_frame(input string tag, input bit is_rd,
                               input logic [15:0] a, input logic [15:0] d);
        chk(cap[0] == (is_rd ? 8'hA9 : 8'hA8), "R2", {tag, " command"}, cap[0], is_rd ? 8'hA9 : 8'hA8);
        chk(cap[1] == a[7:0], "R3", {tag, " addr lo"}, cap[1], a[7:0]);
        chk(cap[2] == a[15:8], "R3", {tag, " addr hi"}, cap[2], a[15:8]);
        if (!is_rd) begin
            chk(cap[3] == d[7:0], "R4", {tag, " data lo"}, cap[3], d[7:0]);
            chk(cap[4] == d[15:8], "R4", {tag, " data hi"}, cap[4], d[15:8]);
        end
    endtask

    task automatic check_end(input string tag, input bit exp_err);
        chk(err_v == exp_err, "R12", {tag, " err with done"}, err_v, exp_err);
        chk(done_after == 1'b0, "R12", {tag, " done one cycle"}, done_after, 0);
        chk(!sck_oe && !sda_oe && !busy, "R9", {tag, " lines released"},
            {sck_oe, sda_oe, busy}, 0);
        chk(hi_changes == 2, "R1", {tag, " data edges with clock high"}, hi_changes, 2);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !err, "R11", "reset status", {busy, done, err}, 0);
        chk(!sck_oe && !sda_oe, "R9", "reset lines released", {sck_oe, sda_oe}, 0);
    endtask

    task automatic t_write_slow;
        txn(1'b0, 16'h3C5A, 16'hBEEF, 8'd2, -1, 0, 16'h0, 1'b0);
        check_frame("write hd2", 1'b0, 16'h3C5A, 16'hBEEF);
        check_end("write hd2", 1'b0);
        chk(cyc == 1 + 150*3, "R10", "write hd2 cycles", cyc, 1 + 150*3);
        chk(rises == 50, "R9", "write clock rises incl. 3 closing", rises, 50);
    endtask

    task automatic t_write_fast;
        txn(1'b0, 16'h0081, 16'h7E01, 8'd0, -1, 0, 16'h0, 1'b0);
        check_frame("write hd0", 1'b0, 16'h0081, 16'h7E01);
        check_end("write hd0", 1'b0);
        chk(cyc == 1 + 150, "R10", "write hd0 cycles", cyc, 1 + 150);
    endtask

    task automatic t_read;
        txn(1'b1, 16'hA55A, 16'h0, 8'd1, -1, 0, 16'hC3E7, 1'b0);
        check_frame("read", 1'b1, 16'hA55A, 16'h0);
        check_end("read", 1'b0);
        chk(rdata_v == 16'hC3E7, "R5", "read data", rdata_v, 16'hC3E7);
        chk(mack_oe[0] && mack_v[0] == 1'b0, "R6", "ack after low byte", {mack_oe[0], mack_v[0]}, 2'b10);
        chk(mack_oe[1] && mack_v[1] == 1'b1, "R6", "ack after high byte", {mack_oe[1], mack_v[1]}, 2'b11);
        chk(cyc == 1 + 150*2, "R10", "read cycles", cyc, 1 + 150*2);
    endtask

    task automatic t_retry_ok;
        txn(1'b0, 16'h1234, 16'h5678, 8'd0, 1, 5, 16'h0, 1'b0);
        check_frame("five refusals", 1'b0, 16'h1234, 16'h5678);
        chk(!aborted && err_v == 1'b0, "R7", "five refusals then ack", err_v, 0);
        chk(cyc == 1 + 150 + 15, "R7", "five refusals cycles", cyc, 1 + 165);
        chk(rises == 55, "R7", "five refusals rises", rises, 55);
    endtask

    task automatic t_abort;
        txn(1'b0, 16'h4321, 16'h8765, 8'd1, 2, 6, 16'h0, 1'b0);
        chk(aborted, "R8", "six refusals seen by device", aborted, 1);
        check_end("abort", 1'b1);
        chk(cyc == 1 + 111*2, "R8", "abort cycles", cyc, 1 + 111*2);
        chk(rises == 2 + 18 + 8 + 6 + 3, "R8", "abort rises", rises, 37);
    endtask

    task automatic t_busy_start;
        txn(1'b0, 16'h0F0F, 16'hF00D, 8'd0, -1, 0, 16'h0, 1'b1);
        check_frame("start while busy", 1'b0, 16'h0F0F, 16'hF00D);
        repeat (20) @(negedge clk);
        chk(!busy && !sck_oe, "R11", "no second transfer", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_slow();
        t_write_fast();
        t_read();
        t_retry_ok();
        t_abort();
        t_busy_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule